// File: doc/BRIEF.md
# Instruction Loop Cache Controller

This block lets a processor run a short block of instructions many times without paying for program-memory fetches after the first pass. A loop command names how many words the block holds (N, 1 to 15) and how many times to run it (K). On the first pass the controller reads each word from program memory, hands it to the execution pipeline and keeps a copy in a small store. Every later pass is replayed from that store. A replay command runs whatever is already stored another K times, with no reload.

The iteration count can be given directly in the command (1 to 127). A zero count field instead selects a 7-bit loop-count register that software writes beforehand. That register is cleared when a register-driven loop finishes, so it must be rewritten before each such command. Every issued instruction carries a timing class that tells the pipeline whether it runs with in-store timing, normal memory timing, or the two-cycle timing given to the closing word of the first pass. Decoding and execution are outside the block. An external predecoder tells the controller which fetched words may not be placed in the store.

Top module: `loop_cache`

## Requirements
- R1: A load command (`cmd_redo`=0) is accepted in one cycle, and the first word is issued in the next cycle. The first pass then fetches N consecutive words starting at `cmd_addr`, one per cycle, with `fetch_req` high. Each word is issued with `ins_timing`=1 (memory timing), except the N-th, which is issued with `ins_timing`=2 (two-cycle) and is followed by exactly one cycle with `ins_valid` low while `busy` stays high.
- R2: On passes 2 to K-1, every word comes from the store in block order, `fetch_req` stays low, and `ins_timing`=0 (store timing).
- R3: On pass K (K at least 2), words come from the store with `ins_timing`=0, except the last word of the block, which is issued with `ins_timing`=1. `loop_done` is high in the cycle that word is issued.
- R4: A command whose `cmd_count` is 0 takes its iteration count from the loop-count register (`cnt_rdata`, 7 bits unsigned). Any value from 1 to 127 in `cmd_count` is used directly.
- R5: When a loop that took its count from the register finishes, `cnt_rdata` reads 0 from the next cycle on. A write through `cnt_wr` in the same cycle as that finish takes priority, and the written value is kept.
- R6: A replay command (`cmd_redo`=1) takes two cycles. Its first word is issued two cycles after it is accepted. It then runs the stored block K times with `fetch_req` low throughout, using the timing classes of R2 and R3. With K=1 this is a single pass whose last word has `ins_timing`=1.
- R7: A replay command given while the store holds no complete block raises `err_redo_empty` for one cycle and is otherwise ignored.
- R8: If `fetch_uncache` is high for a word fetched during the first pass, that word is not issued. The loop is abandoned, `err_uncache` pulses for one cycle, and the store is left empty, so a following replay is refused as in R7.
- R9: A load command with N=0, or any command whose iteration count resolves to 0, raises `err_bad_cmd` for one cycle and is ignored.
- R10: After a load loop completes, `pc_next` equals `cmd_addr`+N. After a replay completes, `pc_next` equals the `cmd_addr` given with the replay.
- R11: Commands presented while `busy` is high are ignored and raise no error.
- R12: After reset the block is idle: `busy`, `ins_valid` and all error outputs are low, `cnt_rdata` is 0, `pc_next` is 0, and the store is empty.
- R13: K=1 with a load command gives a single fetched pass, ending with the two-cycle word and its idle cycle. `loop_done` is high together with that word, and no replay follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Loop command present this cycle |
| cmd_redo | input | 1 | 0 = load and run, 1 = replay stored block |
| cmd_count | input | 7 | Iteration count; 0 selects the loop-count register |
| cmd_len | input | 4 | Block length N (load only) |
| cmd_addr | input | AW | Address of the word following the command |
| cnt_wr | input | 1 | Write strobe for the loop-count register |
| cnt_wdata | input | 7 | Value to write into the loop-count register |
| cnt_rdata | output | 7 | Current loop-count register value |
| fetch_req | output | 1 | Program-memory read this cycle |
| fetch_addr | output | AW | Program-memory read address |
| fetch_data | input | IW | Word returned for `fetch_addr` in the same cycle |
| fetch_uncache | input | 1 | Predecoder: the fetched word may not be stored |
| ins_valid | output | 1 | Instruction issued this cycle |
| ins_data | output | IW | Issued instruction word |
| ins_timing | output | 2 | 0 store timing, 1 memory timing, 2 two-cycle memory timing |
| loop_done | output | 1 | Final word of the final pass is being issued |
| busy | output | 1 | A loop is in progress |
| pc_next | output | AW | Address where execution continues after the loop |
| err_bad_cmd | output | 1 | One-cycle pulse: zero length or zero count |
| err_redo_empty | output | 1 | One-cycle pulse: replay with an empty store |
| err_uncache | output | 1 | One-cycle pulse: forbidden word met during load |

## Verification
The interesting collision is a software write to the loop-count register landing in the same cycle as the finish of a loop that took its count from that register. There, the clear-on-finish and the write compete. The bench provokes it by raising `cnt_wr` exactly in the cycle where its reference model expects `loop_done`. It then requires the written value to survive, and in a separate run, without a write, requires the register to read zero. A second overlap, a command arriving while a loop is running, is provoked by injecting a zero-length load mid-loop. The run is judged by an unchanged instruction stream and the absence of any error pulse.

// File: rtl/lc_pkg.sv
// Shared types for the loop cache controller.
// Assumes: timing codes are fixed by the pipeline that consumes ins_timing.
package lc_pkg;

    typedef enum logic [1:0] {
        TM_CACHE = 2'd0,   // word runs with store timing
        TM_MEM   = 2'd1,   // word runs with normal memory timing
        TM_MEM2  = 2'd2    // closing word of the first pass, two cycles
    } timing_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_REDO_WAIT,
        S_LOAD,
        S_GAP,
        S_REPLAY
    } seq_state_e;

endpackage

// File: rtl/lc_count_reg.sv
// Loop-count register: written by software, cleared when a loop that
// used it finishes. Assumes a write and a clear may coincide; the write wins.
module lc_count_reg #(
    parameter int CW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [CW-1:0] wdata,
    input  logic          clr,
    output logic [CW-1:0] q
);

    // Hold the count; software write has priority over the end-of-loop clear.
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= '0;
        else if (wr)  q <= wdata;
        else if (clr) q <= '0;
    end

    a_r5_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> q == $past(wdata));

    a_r5_clear_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !wr) |=> q == '0);

endmodule

// File: rtl/lc_store.sv
// Instruction store: one register per slot, written during the load pass,
// read by slot index during replay. Assumes indices beyond DEPTH read zero.
module lc_store #(
    parameter int IW    = 16,
    parameter int DEPTH = 15,
    parameter int LW    = 4
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [LW-1:0] wr_idx,
    input  logic [IW-1:0] wr_data,
    input  logic [LW-1:0] rd_idx,
    output logic [IW-1:0] rd_data
);

    logic [IW-1:0] slot [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_slot
        // Capture the fetched word into slot e when it is addressed.
        always_ff @(posedge clk) begin
            if (wr_en && (int'(wr_idx) == e)) slot[e] <= wr_data;
        end
    end

    // Select the replayed word.
    always_comb begin
        rd_data = '0;
        for (int s = 0; s < DEPTH; s++) begin
            if (int'(rd_idx) == s) rd_data = slot[s];
        end
    end

endmodule

// File: rtl/lc_seq.sv
// Loop sequencer: accepts load/replay commands, walks the first pass from
// program memory, then the stored passes, and classifies each issued word.
// Assumes fetch_data and fetch_uncache answer fetch_addr in the same cycle.
module lc_seq
    import lc_pkg::*;
#(
    parameter int IW      = 16,
    parameter int AW      = 16,
    parameter int CW      = 7,
    parameter int MAX_LEN = 15,
    parameter int LW      = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic          cmd_redo,
    input  logic [CW-1:0] cmd_count,
    input  logic [LW-1:0] cmd_len,
    input  logic [AW-1:0] cmd_addr,
    input  logic [CW-1:0] cnt_val,
    output logic          cnt_clr,
    output logic          fetch_req,
    output logic [AW-1:0] fetch_addr,
    input  logic [IW-1:0] fetch_data,
    input  logic          fetch_uncache,
    output logic          wr_en,
    output logic [LW-1:0] wr_idx,
    output logic [IW-1:0] wr_data,
    output logic [LW-1:0] rd_idx,
    input  logic [IW-1:0] rd_data,
    output logic          ins_valid,
    output logic [IW-1:0] ins_data,
    output logic [1:0]    ins_timing,
    output logic          loop_done,
    output logic          busy,
    output logic [AW-1:0] pc_next,
    output logic          err_bad_cmd,
    output logic          err_redo_empty,
    output logic          err_uncache
);

    seq_state_e    state;
    logic [LW-1:0] idx;
    logic [LW-1:0] len;
    logic [CW-1:0] rem;
    logic [AW-1:0] addr;
    logic          from_reg;
    logic          cache_ok;

    logic [CW-1:0] k_eff;
    logic          use_reg;
    logic          len_ok;
    logic          is_last;
    logic          final_pass;
    logic          load_ok;
    timing_e       tm;

    // Resolve the command's iteration count and length legality.
    always_comb begin
        use_reg = (cmd_count == '0);
        k_eff   = use_reg ? cnt_val : cmd_count;
        len_ok  = (int'(cmd_len) >= 1) && (int'(cmd_len) <= MAX_LEN);
    end

    // Position flags and output decode for the current cycle.
    always_comb begin
        is_last    = (idx == len - LW'(1));
        final_pass = (rem == CW'(1));
        load_ok    = (state == S_LOAD) && !fetch_uncache;
        fetch_req  = (state == S_LOAD);
        fetch_addr = addr;
        ins_valid  = load_ok || (state == S_REPLAY);
        ins_data   = (state == S_LOAD) ? fetch_data : rd_data;
        tm         = TM_CACHE;
        if (state == S_LOAD)
            tm = is_last ? TM_MEM2 : TM_MEM;
        else if (state == S_REPLAY && is_last && final_pass)
            tm = TM_MEM;
        ins_timing = tm;
        loop_done  = ins_valid && is_last && final_pass;
        cnt_clr    = loop_done && from_reg;
        wr_en      = load_ok;
        wr_idx     = idx;
        wr_data    = fetch_data;
        rd_idx     = idx;
        busy       = (state != S_IDLE);
        pc_next    = addr;
    end

    // Sequencer state, counters and one-cycle error pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state          <= S_IDLE;
            idx            <= '0;
            len            <= '0;
            rem            <= '0;
            addr           <= '0;
            from_reg       <= 1'b0;
            cache_ok       <= 1'b0;
            err_bad_cmd    <= 1'b0;
            err_redo_empty <= 1'b0;
            err_uncache    <= 1'b0;
        end else begin
            err_bad_cmd    <= 1'b0;
            err_redo_empty <= 1'b0;
            err_uncache    <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (cmd_valid) begin
                        if (cmd_redo) begin
                            if (!cache_ok) begin
                                err_redo_empty <= 1'b1;
                            end else if (k_eff == '0) begin
                                err_bad_cmd <= 1'b1;
                            end else begin
                                rem      <= k_eff;
                                idx      <= '0;
                                addr     <= cmd_addr;
                                from_reg <= use_reg;
                                state    <= S_REDO_WAIT;
                            end
                        end else begin
                            if (!len_ok || k_eff == '0) begin
                                err_bad_cmd <= 1'b1;
                            end else begin
                                len      <= cmd_len;
                                rem      <= k_eff;
                                idx      <= '0;
                                addr     <= cmd_addr;
                                from_reg <= use_reg;
                                cache_ok <= 1'b0;
                                state    <= S_LOAD;
                            end
                        end
                    end
                end
                S_REDO_WAIT: state <= S_REPLAY;
                S_LOAD: begin
                    if (fetch_uncache) begin
                        err_uncache <= 1'b1;
                        from_reg    <= 1'b0;
                        state       <= S_IDLE;
                    end else begin
                        addr <= addr + AW'(1);
                        if (is_last) begin
                            idx      <= '0;
                            rem      <= rem - CW'(1);
                            cache_ok <= 1'b1;
                            state    <= S_GAP;
                        end else begin
                            idx <= idx + LW'(1);
                        end
                    end
                end
                S_GAP: state <= (rem == '0) ? S_IDLE : S_REPLAY;
                S_REPLAY: begin
                    if (is_last) begin
                        idx <= '0;
                        rem <= rem - CW'(1);
                        if (final_pass) state <= S_IDLE;
                    end else begin
                        idx <= idx + LW'(1);
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    a_r2_cache_word_no_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && ins_timing == TM_CACHE) |-> !fetch_req);

    a_r1_idle_after_double: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && ins_timing == TM_MEM2) |=> (!ins_valid && busy));

    a_r8_forbidden_not_issued: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && fetch_uncache) |-> !ins_valid);

    a_r11_busy_no_error: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_valid) |=> (!err_bad_cmd && !err_redo_empty));

    a_r7_one_error: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({err_bad_cmd, err_redo_empty, err_uncache}));

endmodule

// File: rtl/loop_cache.sv
// Loop cache controller top: ties the sequencer, the instruction store and
// the loop-count register together. Assumes single-cycle program memory.
module loop_cache #(
    parameter int IW      = 16,
    parameter int AW      = 16,
    parameter int CW      = 7,
    parameter int MAX_LEN = 15
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cmd_valid,
    input  logic                         cmd_redo,
    input  logic [CW-1:0]                cmd_count,
    input  logic [$clog2(MAX_LEN+1)-1:0] cmd_len,
    input  logic [AW-1:0]                cmd_addr,
    input  logic                         cnt_wr,
    input  logic [CW-1:0]                cnt_wdata,
    output logic [CW-1:0]                cnt_rdata,
    output logic                         fetch_req,
    output logic [AW-1:0]                fetch_addr,
    input  logic [IW-1:0]                fetch_data,
    input  logic                         fetch_uncache,
    output logic                         ins_valid,
    output logic [IW-1:0]                ins_data,
    output logic [1:0]                   ins_timing,
    output logic                         loop_done,
    output logic                         busy,
    output logic [AW-1:0]                pc_next,
    output logic                         err_bad_cmd,
    output logic                         err_redo_empty,
    output logic                         err_uncache
);

    localparam int LW = $clog2(MAX_LEN + 1);

    logic          cnt_clr;
    logic          wr_en;
    logic [LW-1:0] wr_idx;
    logic [IW-1:0] wr_data;
    logic [LW-1:0] rd_idx;
    logic [IW-1:0] rd_data;

    lc_count_reg #(.CW(CW)) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (cnt_wr),
        .wdata (cnt_wdata),
        .clr   (cnt_clr),
        .q     (cnt_rdata)
    );

    lc_store #(.IW(IW), .DEPTH(MAX_LEN), .LW(LW)) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );

    lc_seq #(.IW(IW), .AW(AW), .CW(CW), .MAX_LEN(MAX_LEN), .LW(LW)) u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .cmd_valid      (cmd_valid),
        .cmd_redo       (cmd_redo),
        .cmd_count      (cmd_count),
        .cmd_len        (cmd_len),
        .cmd_addr       (cmd_addr),
        .cnt_val        (cnt_rdata),
        .cnt_clr        (cnt_clr),
        .fetch_req      (fetch_req),
        .fetch_addr     (fetch_addr),
        .fetch_data     (fetch_data),
        .fetch_uncache  (fetch_uncache),
        .wr_en          (wr_en),
        .wr_idx         (wr_idx),
        .wr_data        (wr_data),
        .rd_idx         (rd_idx),
        .rd_data        (rd_data),
        .ins_valid      (ins_valid),
        .ins_data       (ins_data),
        .ins_timing     (ins_timing),
        .loop_done      (loop_done),
        .busy           (busy),
        .pc_next        (pc_next),
        .err_bad_cmd    (err_bad_cmd),
        .err_redo_empty (err_redo_empty),
        .err_uncache    (err_uncache)
    );

endmodule

// File: tb/loop_cache_bench.sv
module loop_cache_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_redo = 1'b0;
    logic [6:0]  cmd_count = '0;
    logic [3:0]  cmd_len = '0;
    logic [15:0] cmd_addr = '0;
    logic        cnt_wr = 1'b0;
    logic [6:0]  cnt_wdata = '0;
    logic [6:0]  cnt_rdata;
    logic        fetch_req;
    logic [15:0] fetch_addr;
    logic [15:0] fetch_data;
    logic        fetch_uncache;
    logic        ins_valid;
    logic [15:0] ins_data;
    logic [1:0]  ins_timing;
    logic        loop_done;
    logic        busy;
    logic [15:0] pc_next;
    logic        err_bad_cmd;
    logic        err_redo_empty;
    logic        err_uncache;

    int checks = 0;
    int failures = 0;
    int bad_addr = -1;
    bit finished = 0;

    always #2 clk = ~clk;

    function automatic logic [15:0] memw(input logic [15:0] a);
        return (a * 16'h03b1) ^ 16'h5a5a;
    endfunction

    assign fetch_data    = memw(fetch_addr);
    assign fetch_uncache = fetch_req && (int'(fetch_addr) == bad_addr);

    loop_cache u_loop_cache (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_redo(cmd_redo),
        .cmd_count(cmd_count), .cmd_len(cmd_len), .cmd_addr(cmd_addr),
        .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .cnt_rdata(cnt_rdata),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_data(fetch_data),
        .fetch_uncache(fetch_uncache), .ins_valid(ins_valid), .ins_data(ins_data),
        .ins_timing(ins_timing), .loop_done(loop_done), .busy(busy),
        .pc_next(pc_next), .err_bad_cmd(err_bad_cmd),
        .err_redo_empty(err_redo_empty), .err_uncache(err_uncache)
    );

    // Behavioural reference: one expected record per clock cycle.
    typedef struct {
        bit          v;
        logic [15:0] d;
        int          t;
        bit          f;
        logic [15:0] fa;
        bit          b;
        bit          dn;
        bit [2:0]    e;   // {bad_cmd, redo_empty, uncache}
        string       tag;
    } exp_t;

    exp_t        exp_q[$];
    logic [15:0] m_store[$];
    bit          m_full = 0;
    logic [6:0]  m_cnt = '0;

    task automatic push(bit v, logic [15:0] d, int t, bit f, logic [15:0] fa,
                        bit b, bit dn, bit [2:0] e, string tag);
        exp_t x;
        x.v = v; x.d = d; x.t = t; x.f = f; x.fa = fa;
        x.b = b; x.dn = dn; x.e = e; x.tag = tag;
        exp_q.push_back(x);
    endtask

    task automatic check(bit ok, string tag, string what, int act, int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    // Replay passes of the stored block.
    task automatic exp_replays(int first_pass, int k, string tag);
        for (int p = first_pass; p <= k; p++)
            for (int i = 0; i < m_store.size(); i++) begin
                bit lastw = (i == m_store.size() - 1);
                push(1, m_store[i], (p == k && lastw) ? 1 : 0, 0, 0, 1,
                     p == k && lastw, 3'b000, tag);
            end
    endtask

    task automatic exp_do(logic [15:0] a, int n, int kf, string tag);
        int k = (kf == 0) ? int'(m_cnt) : kf;
        m_store.delete();
        for (int i = 0; i < n; i++) begin
            logic [15:0] w = memw(a + 16'(i));
            m_store.push_back(w);
            push(1, w, (i == n - 1) ? 2 : 1, 1, a + 16'(i), 1,
                 (k == 1) && (i == n - 1), 3'b000, tag);
        end
        push(0, 0, 0, 0, 0, 1, 0, 3'b000, tag);
        exp_replays(2, k, tag);
        push(0, 0, 0, 0, 0, 0, 0, 3'b000, tag);
        m_full = 1;
        if (kf == 0) m_cnt = '0;
    endtask

    task automatic exp_redo(int kf, string tag);
        int k = (kf == 0) ? int'(m_cnt) : kf;
        push(0, 0, 0, 0, 0, 1, 0, 3'b000, tag);
        exp_replays(1, k, tag);
        push(0, 0, 0, 0, 0, 0, 0, 3'b000, tag);
        if (kf == 0) m_cnt = '0;
    endtask

    task automatic issue(bit redo, logic [6:0] cnt, logic [3:0] len, logic [15:0] a);
        cmd_valid = 1; cmd_redo = redo; cmd_count = cnt; cmd_len = len; cmd_addr = a;
    endtask

    task automatic wr_cnt(logic [6:0] v);
        cnt_wr = 1; cnt_wdata = v;
        @(negedge clk);
        cnt_wr = 0;
        m_cnt = v;
    endtask

    // Compare the design to the queued expectation on every clock.
    task automatic play(int inj, bit wr_end, logic [6:0] wv);
        int n = exp_q.size();
        for (int j = 0; j < n; j++) begin
            exp_t x = exp_q[j];
            bit ok;
            @(negedge clk);
            cmd_valid = 0; cnt_wr = 0;
            ok = (ins_valid == x.v) && (fetch_req == x.f) && (busy == x.b) &&
                 (loop_done == x.dn) &&
                 ({err_bad_cmd, err_redo_empty, err_uncache} == x.e) &&
                 (!x.v || (ins_data == x.d && int'(ins_timing) == x.t)) &&
                 (!x.f || fetch_addr == x.fa);
            checks++;
            if (!ok) begin
                failures++;
                $display("FAIL %s cyc%0d actual v%0d d%h t%0d f%0d a%h b%0d dn%0d e%b expected v%0d d%h t%0d f%0d a%h b%0d dn%0d e%b",
                         x.tag, j, ins_valid, ins_data, ins_timing, fetch_req, fetch_addr,
                         busy, loop_done, {err_bad_cmd, err_redo_empty, err_uncache},
                         x.v, x.d, x.t, x.f, x.fa, x.b, x.dn, x.e);
            end
            if (j == inj) issue(0, 7'd1, 4'd0, 16'h0);   // R11: would be refused if seen
            if (wr_end && x.dn) begin cnt_wr = 1; cnt_wdata = wv; m_cnt = wv; end
        end
        exp_q.delete();
        @(negedge clk);
        cmd_valid = 0; cnt_wr = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R12: reset state
        check(!busy && !ins_valid && !loop_done, "R12", "busy/valid", busy, 0);
        check(cnt_rdata == 0, "R12", "cnt", cnt_rdata, 0);
        check(pc_next == 0, "R12", "pc", pc_next, 0);
        check({err_bad_cmd, err_redo_empty, err_uncache} == 0, "R12", "err", 0, 0);

        // R7: replay with empty store
        issue(1, 7'd3, 4'd0, 16'h0050);
        push(0, 0, 0, 0, 0, 0, 0, 3'b010, "R7");
        push(0, 0, 0, 0, 0, 0, 0, 3'b000, "R7");
        play(-1, 0, 0);

        // R1 R2 R3: load N=4 K=3
        issue(0, 7'd3, 4'd4, 16'h0100);
        exp_do(16'h0100, 4, 3, "R1R2R3");
        play(-1, 0, 0);
        check(pc_next == 16'h0104, "R10", "pc after load", pc_next, 16'h0104);

        // R6: replay K=2, then K=1
        issue(1, 7'd2, 4'd0, 16'h0200);
        exp_redo(2, "R6");
        play(-1, 0, 0);
        check(pc_next == 16'h0200, "R10", "pc after replay", pc_next, 16'h0200);
        issue(1, 7'd1, 4'd0, 16'h0210);
        exp_redo(1, "R6");
        play(-1, 0, 0);

        // R4 R5: register-driven load, register cleared at finish
        wr_cnt(7'd5);
        check(cnt_rdata == 7'd5, "R5", "cnt write", cnt_rdata, 5);
        issue(0, 7'd0, 4'd3, 16'h0300);
        exp_do(16'h0300, 3, 0, "R4");
        play(-1, 0, 0);
        check(cnt_rdata == 0, "R5", "cnt cleared", cnt_rdata, 0);

        // R13: K=1 single fetched pass; N=15 boundary; K=127 boundary
        issue(0, 7'd1, 4'd1, 16'h0400);
        exp_do(16'h0400, 1, 1, "R13");
        play(-1, 0, 0);
        check(pc_next == 16'h0401, "R10", "pc K=1", pc_next, 16'h0401);
        issue(0, 7'd2, 4'd15, 16'h0500);
        exp_do(16'h0500, 15, 2, "R1 N=15");
        play(-1, 0, 0);
        issue(0, 7'd127, 4'd1, 16'h0580);
        exp_do(16'h0580, 1, 127, "R4 K=127");
        play(-1, 0, 0);

        // R5: write coinciding with register-driven replay finish wins
        wr_cnt(7'd2);
        issue(1, 7'd0, 4'd0, 16'h0590);
        exp_redo(0, "R5");
        play(-1, 1, 7'd9);
        check(cnt_rdata == 7'd9, "R5", "write at finish", cnt_rdata, 9);

        // R9: zero length, zero resolved count
        issue(0, 7'd2, 4'd0, 16'h0700);
        push(0, 0, 0, 0, 0, 0, 0, 3'b100, "R9");
        push(0, 0, 0, 0, 0, 0, 0, 3'b000, "R9");
        play(-1, 0, 0);
        wr_cnt(7'd0);
        issue(0, 7'd0, 4'd2, 16'h0700);
        push(0, 0, 0, 0, 0, 0, 0, 3'b100, "R9");
        push(0, 0, 0, 0, 0, 0, 0, 3'b000, "R9");
        play(-1, 0, 0);
        check(pc_next == 16'h0590, "R9", "pc unchanged", pc_next, 16'h0590);

        // R11: command injected while busy is ignored
        issue(0, 7'd3, 4'd2, 16'h0800);
        exp_do(16'h0800, 2, 3, "R11");
        play(1, 0, 0);

        // R8: forbidden word at offset 2 abandons the load
        bad_addr = 16'h0602;
        issue(0, 7'd4, 4'd5, 16'h0600);
        push(1, memw(16'h0600), 1, 1, 16'h0600, 1, 0, 3'b000, "R8");
        push(1, memw(16'h0601), 1, 1, 16'h0601, 1, 0, 3'b000, "R8");
        push(0, 0, 0, 1, 16'h0602, 1, 0, 3'b000, "R8");
        push(0, 0, 0, 0, 0, 0, 0, 3'b001, "R8");
        push(0, 0, 0, 0, 0, 0, 0, 3'b000, "R8");
        play(-1, 0, 0);
        bad_addr = -1;
        issue(1, 7'd2, 4'd0, 16'h0610);
        push(0, 0, 0, 0, 0, 0, 0, 3'b010, "R8");
        push(0, 0, 0, 0, 0, 0, 0, 3'b000, "R8");
        play(-1, 0, 0);

        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule